// File: doc/BRIEF.md
# Output Latch Port with Bitwise Set, Clear and Toggle

This block is the data side of a 32-pin general-purpose I/O port. It keeps an output latch that drives the pads. It also samples the pad input levels through a synchronizer chain. Software reaches both through a small word-addressed register bus. The bus has an address, a write strobe with write data, a read strobe, and read data that is returned one cycle later.

The output latch can be loaded in full. Three write-only alias offsets change only the bits that are 1 in the written mask: one forces those bits high, one forces them low, and one inverts them. Any single output bit can therefore be changed without reading the latch first. This removes the race between two agents that share the port. Pin direction, pin muxing and pad settings are handled elsewhere.

Top module: `gpio_atomic_port`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), pin_out is all zeros and bus_rdata is zero.
- R2: A write to offset 0x00 replaces every bit of the output latch with bus_wdata. pin_out shows the new value from the clock edge that accepts the write.
- R3: A write to offset 0x04 drives to 1 every output bit whose mask bit is 1. Bits whose mask bit is 0 keep their value.
- R4: A write to offset 0x08 drives to 0 every output bit whose mask bit is 1. Bits whose mask bit is 0 keep their value.
- R5: A write to offset 0x0C inverts every output bit whose mask bit is 1. Bits whose mask bit is 0 keep their value.
- R6: A read of offset 0x00 returns the output latch as it was when the read was accepted.
- R7: A read of offset 0x10 returns the pad input levels after a two-flop synchronizer, with bit n taken from pin n. A level that is held steady for two clock edges before the read is accepted is returned.
- R8: Reads of the alias offsets 0x04, 0x08 and 0x0C return zero. Reads of any unmapped offset also return zero.
- R9: Writes to offset 0x10 and to unmapped offsets leave the output latch unchanged. With no write, the latch holds its value.
- R10: bus_rdata is registered. It carries the read result in the cycle after bus_rd is sampled high, and it is zero in the cycle after bus_rd is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| pin_in | input | 32 | Pad input levels (asynchronous) |
| pin_out | output | 32 | Output latch driving the pads |

## Verification
The alias operations are tried with walking single-bit masks over all 32 bit positions, each applied to a latch that is first all ones or all zeros. This shows that each mask bit touches exactly its own pin and that the other bits are left alone. Pseudo-random latch contents combined with pseudo-random masks then separate set, clear and toggle from one another and from a full load. Walking-one and alternating patterns on the pad inputs check the bit order of the input path and its two-cycle synchronizer delay. A sweep of every byte offset confirms that reads of aliases and holes return zero and that writes to them do not disturb the latch.

// File: rtl/gpio_port_pkg.sv
// Shared constants and types for the GPIO data port.
// Assumes byte offsets on a word-aligned register bus.
package gpio_port_pkg;

    localparam int OFF_OUT = 'h00;
    localparam int OFF_SET = 'h04;
    localparam int OFF_CLR = 'h08;
    localparam int OFF_TOG = 'h0C;
    localparam int OFF_IN  = 'h10;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_LOAD = 3'd1,
        OP_SET  = 3'd2,
        OP_CLR  = 3'd3,
        OP_TOG  = 3'd4
    } wr_op_e;

    typedef enum logic [1:0] {
        SEL_ZERO = 2'd0,
        SEL_OUT  = 2'd1,
        SEL_IN   = 2'd2
    } rd_sel_e;

endpackage

// File: rtl/gpio_in_sync.sv
// Multi-stage synchronizer for the pad inputs.
// Assumes STAGES >= 2. Each bit is sampled independently; no bus coherency.
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    // First stage captures the asynchronous pad levels.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage re-samples the stage before it.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign sync_out = chain[LAST];

endmodule

// File: rtl/gpio_out_latch.sv
// Output latch with full load and masked set, clear and toggle updates.
// Assumes at most one operation per cycle, as chosen by the decoder.
module gpio_out_latch
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_op_e           op,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    // Apply the selected operation to the latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            case (op)
                OP_LOAD: q <= wdata;
                OP_SET:  q <= q | wdata;
                OP_CLR:  q <= q & ~wdata;
                OP_TOG:  q <= q ^ wdata;
                default: q <= q;
            endcase
        end
    end

endmodule

// File: rtl/gpio_read_mux.sv
// Registered read-data path: selects a source and returns it one cycle later.
// Assumes the select has already been decoded from the address.
module gpio_read_mux
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd,
    input  rd_sel_e          sel,
    input  logic [WIDTH-1:0] out_val,
    input  logic [WIDTH-1:0] in_val,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] pick;

    // Choose the read source; aliases and holes give zero.
    always_comb begin
        case (sel)
            SEL_OUT: pick = out_val;
            SEL_IN:  pick = in_val;
            default: pick = '0;
        endcase
    end

    // Register the result; idle cycles return zero.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= pick;
        else         rdata <= '0;
    end

endmodule

// File: rtl/gpio_atomic_port.sv
// Top of the GPIO data port: decodes bus offsets, owns the output latch,
// synchronizes pad inputs and returns registered read data.
// Assumes a single-cycle write strobe and a byte-offset address.
module gpio_atomic_port
    import gpio_port_pkg::*;
#(
    parameter int PINS        = 32,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [PINS-1:0]   bus_wdata,
    input  logic              bus_rd,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out
);
    localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(OFF_OUT);
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFF_SET);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFF_CLR);
    localparam logic [ADDR_W-1:0] A_TOG = ADDR_W'(OFF_TOG);
    localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(OFF_IN);

    wr_op_e          wr_op;
    rd_sel_e         rd_sel;
    logic [PINS-1:0] in_sync;
    logic [PINS-1:0] latch_q;

    // Decode the write offset into one latch operation.
    always_comb begin
        wr_op = OP_NONE;
        if (bus_wr) begin
            case (bus_addr)
                A_OUT:   wr_op = OP_LOAD;
                A_SET:   wr_op = OP_SET;
                A_CLR:   wr_op = OP_CLR;
                A_TOG:   wr_op = OP_TOG;
                default: wr_op = OP_NONE;
            endcase
        end
    end

    // Decode the read offset into a data source.
    always_comb begin
        case (bus_addr)
            A_OUT:   rd_sel = SEL_OUT;
            A_IN:    rd_sel = SEL_IN;
            default: rd_sel = SEL_ZERO;
        endcase
    end

    gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (in_sync)
    );

    gpio_out_latch #(.WIDTH(PINS)) latch_i (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (wr_op),
        .wdata (bus_wdata),
        .q     (latch_q)
    );

    gpio_read_mux #(.WIDTH(PINS)) rmux_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (bus_rd),
        .sel     (rd_sel),
        .out_val (latch_q),
        .in_val  (in_sync),
        .rdata   (bus_rdata)
    );

    assign pin_out = latch_q;

    AST_LOAD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_OUT) |=> (pin_out == $past(bus_wdata))); // R2
    AST_SET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_SET) |=> (pin_out == ($past(pin_out) | $past(bus_wdata)))); // R3
    AST_CLR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CLR) |=> ((pin_out & $past(bus_wdata)) == '0)); // R4
    AST_TOG_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_TOG) |=> ((pin_out ^ $past(pin_out)) == $past(bus_wdata))); // R5
    AST_HOLD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr || bus_addr == A_IN || bus_addr > A_IN) |=> $stable(pin_out)); // R9
    AST_ALIAS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != A_OUT && bus_addr != A_IN) |=> (bus_rdata == '0)); // R8
    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd) |=> (bus_rdata == '0)); // R10
    AST_READ_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_OUT) |=> (bus_rdata == $past(pin_out))); // R6

endmodule

// File: tb/gpio_atomic_port_tb_top.sv
module gpio_atomic_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] model = '0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    gpio_atomic_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // Inputs change on falling edges; results are sampled on falling edges.
    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic model_write(input logic [4:0] a, input logic [31:0] d);
        case (a)
            5'h00: model = d;
            5'h04: model = model | d;
            5'h08: model = model & ~d;
            5'h0C: model = model ^ d;
            default: model = model;
        endcase
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] rv;
        logic [31:0] m;
        logic [4:0]  op;
        repeat (3) @(negedge clk);
        check("R1 reset pin_out", pin_out, 32'h0);
        check("R1 reset rdata", bus_rdata, 32'h0);
        rst_n = 1'b1;

        // R2 full loads with distinct patterns
        bus_write(5'h00, 32'hA5A5_0F0F); model_write(5'h00, 32'hA5A5_0F0F);
        check("R2 load pattern", pin_out, model);
        bus_write(5'h00, 32'hFFFF_FFFF); model_write(5'h00, 32'hFFFF_FFFF);
        check("R2 load ones", pin_out, model);

        // Walking single-bit masks on each alias
        for (int i = 0; i < 32; i++) begin
            m = 32'h1 << i;
            bus_write(5'h00, 32'h0); model_write(5'h00, 32'h0);
            bus_write(5'h04, m); model_write(5'h04, m);
            check($sformatf("R3 set bit %0d", i), pin_out, m);
            bus_write(5'h00, 32'hFFFF_FFFF); model_write(5'h00, 32'hFFFF_FFFF);
            bus_write(5'h08, m); model_write(5'h08, m);
            check($sformatf("R4 clear bit %0d", i), pin_out, ~m);
            bus_write(5'h0C, m); model_write(5'h0C, m);
            check($sformatf("R5 toggle bit %0d", i), pin_out, 32'hFFFF_FFFF);
            bus_write(5'h0C, m); model_write(5'h0C, m);
            check($sformatf("R5 toggle back bit %0d", i), pin_out, ~m);
        end

        // Pseudo-random operation mix with read-back of the latch
        for (int k = 0; k < 200; k++) begin
            seed = next_rand(seed);
            op = {1'b0, seed[1:0], 2'b00};
            seed = next_rand(seed);
            bus_write(op, seed); model_write(op, seed);
            check($sformatf("R2 R3 R4 R5 mix op %h", op), pin_out, model);
            bus_read(5'h00, rv);
            check("R6 read latch", rv, model);
        end

        // R7 input path: walking ones and alternating patterns
        for (int i = 0; i < 34; i++) begin
            if (i < 32) pin_in = 32'h1 << i;
            else if (i == 32) pin_in = 32'h5555_AAAA;
            else pin_in = 32'hDEAD_BEEF;
            @(negedge clk); @(negedge clk);
            bus_read(5'h10, rv);
            check($sformatf("R7 input pattern %0d", i), rv, pin_in);
        end
        // R7 latency: a change one edge before the read is not yet visible
        pin_in = 32'h0;
        @(negedge clk); @(negedge clk);
        @(negedge clk);
        pin_in = 32'hFFFF_0000;
        bus_addr = 5'h10; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check("R7 sync delay old value", bus_rdata, 32'h0);

        // R8 and R9: sweep every offset except the output register
        bus_write(5'h00, 32'h3C3C_C3C3); model_write(5'h00, 32'h3C3C_C3C3);
        for (int a = 1; a < 32; a++) begin
            bus_read(5'(a), rv);
            if (a != 16) check($sformatf("R8 read zero offset %h", a), rv, 32'h0);
            if (a != 4 && a != 8 && a != 12) begin
                bus_write(5'(a), 32'hFFFF_FFFF);
                check($sformatf("R9 write ignored offset %h", a), pin_out, model);
            end
        end

        // R10: no read means zero read data
        @(negedge clk);
        check("R10 idle rdata", bus_rdata, 32'h0);
        bus_read(5'h00, rv);
        check("R10 read data one cycle later", rv, model);
        @(negedge clk);
        check("R10 rdata returns to zero", bus_rdata, 32'h0);

        // R1 reset again clears a nonzero latch
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears latch", pin_out, 32'h0);
        rst_n = 1'b1;
        summary();
    end

endmodule